// File: doc/BRIEF.md
# Routed Level-2 Interrupt Aggregator

This block gathers a bank of level-sensitive interrupt sources, grouped into 32-bit words, and presents them to several upstream interrupt lines. Every source passes through a two-flop synchroniser into a status register. An enable register per word gates the sources. A routing mask for each pair of line and word then decides which upstream line a source may drive. Lines share the one status/enable bank, but a line only ever reports the causes that its own routing mask gives it.

Software reaches the enable registers, the routing masks and the wake-active masks over a simple register bus. It can read the status registers. Sources are cleared at their origin, and the block itself holds no acknowledge state. A small power state machine has two states. In PS_RUN the effective enable is the enable register. In PS_SLEEP the effective enable is the enable register ORed with the wake-active mask, and a registered wake request reports any qualifying source. Leaving PS_SLEEP brings back the untouched enable value at once.

State machine transitions: PS_RUN goes to PS_SLEEP when `sleep_req` is sampled high, and PS_SLEEP goes back to PS_RUN when `sleep_req` is sampled low. Each state otherwise holds.

Top module: `l2_irq_aggregator`

## Requirements
- R1: Reading byte address 0x04+8*w returns the synchronised raw level of the sources in word w, whether they are enabled or not. Bit i of the read value is source 32*w+i.
- R2: The enable register of word w sits at byte address 0x00+8*w and can be read and written. After reset it holds the parameter `FWD_INIT`. Writes to a status address change nothing.
- R3: `irq_out[p]` is the registered OR, over all words, of status & effective enable & route[p][w]. It rises on the third clock edge after a source input rises (two synchroniser flops plus the output flop).
- R4: The routing mask for line p and word w sits at byte address 0x40+16*p+4*w and can be read and written. After reset it is all ones.
- R5: A line never asserts for a source whose bit is clear in that line's routing mask, even when the source is enabled and another line picks it up.
- R6: Clearing an enable bit masks its source and setting it unmasks it. The change reaches `irq_out` on the clock edge after the write edge.
- R7: Sources are levels that need no acknowledge. An output stays high while its source stays high, and it falls on the third edge after the source falls.
- R8: While in PS_SLEEP, the effective enable is the enable register ORed with the wake-active mask of word w (byte address 0xD0+4*w, reset zero). After the return to PS_RUN, the effective enable is the enable register alone, and that register is unchanged.
- R9: `wake_out` is high only in the cycle after a cycle spent in PS_SLEEP in which some source was set in status, effective enable and at least one line's routing mask. It is zero in PS_RUN.
- R10: A source bit that no line's routing mask covers never asserts a line or `wake_out`, even when it is set in the wake-active mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NWORDS*32 | Level interrupt sources, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sleep_req | input | 1 | High requests the low-power state |
| irq_out | output | NLINES | Upstream interrupt lines |
| wake_out | output | 1 | Wake request while in the low-power state |

## Verification
The assertions assume that bus writes come only as single-cycle strobes with `bus_sel` and `bus_wr` both high. They also assume that `sleep_req` is a clean synchronous level. Stimulus changes every input just after the falling clock edge, so the synchroniser always captures a settled value. Sources are held for at least three cycles before outputs are sampled, and addresses are used only for registers that exist.

// File: rtl/l2_irq_pkg.sv
package l2_irq_pkg;
    typedef logic [31:0] word_t;

    typedef enum logic {
        PS_RUN   = 1'b0,
        PS_SLEEP = 1'b1
    } pwr_state_t;

    localparam int EN_BASE    = 8'h00;
    localparam int STAT_BASE  = 8'h04;
    localparam int ROUTE_BASE = 8'h40;
    localparam int WAKE_BASE  = 8'hD0;

    function automatic logic [7:0] en_addr(input int w);
        return 8'(EN_BASE + 8 * w);
    endfunction

    function automatic logic [7:0] stat_addr(input int w);
        return 8'(STAT_BASE + 8 * w);
    endfunction

    function automatic logic [7:0] route_addr(input int p, input int w);
        return 8'(ROUTE_BASE + 16 * p + 4 * w);
    endfunction

    function automatic logic [7:0] wake_addr(input int w);
        return 8'(WAKE_BASE + 4 * w);
    endfunction
endpackage

// File: rtl/l2_irq_sync.sv
module l2_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q_out    <= '0;
        end else begin
            stage1_q <= d_in;
            q_out    <= stage1_q;
        end
    end
endmodule

// File: rtl/l2_irq_regs.sv
module l2_irq_regs
    import l2_irq_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int NLINES = 2,
    parameter logic [NWORDS*32-1:0] FWD_INIT = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [7:0]                   bus_addr,
    input  word_t                        bus_wdata,
    output word_t                        bus_rdata,
    input  logic [NWORDS-1:0][31:0]      status,
    output logic [NWORDS-1:0][31:0]      en_q,
    output logic [NWORDS-1:0][31:0]      wake_q,
    output logic [NLINES-1:0][NWORDS-1:0][31:0] route_q
);
    logic wr_stb;
    assign wr_stb = bus_sel && bus_wr;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[w]   <= FWD_INIT[w*32 +: 32];
                wake_q[w] <= '0;
            end else if (wr_stb) begin
                if (bus_addr == en_addr(w))   en_q[w]   <= bus_wdata;
                if (bus_addr == wake_addr(w)) wake_q[w] <= bus_wdata;
            end
        end

        for (genvar p = 0; p < NLINES; p++) begin : g_line
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    route_q[p][w] <= '1;
                else if (wr_stb && bus_addr == route_addr(p, w))
                    route_q[p][w] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_addr == en_addr(w))   bus_rdata = en_q[w];
            if (bus_addr == stat_addr(w)) bus_rdata = status[w];
            if (bus_addr == wake_addr(w)) bus_rdata = wake_q[w];
            for (int p = 0; p < NLINES; p++)
                if (bus_addr == route_addr(p, w)) bus_rdata = route_q[p][w];
        end
    end
endmodule

// File: rtl/l2_irq_route.sv
module l2_irq_route #(
    parameter int NWORDS = 2,
    parameter int NLINES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sleeping,
    input  logic [NWORDS-1:0][31:0]      status,
    input  logic [NWORDS-1:0][31:0]      eff_en,
    input  logic [NLINES-1:0][NWORDS-1:0][31:0] route_q,
    output logic [NLINES-1:0]            irq_out,
    output logic                         wake_out
);
    logic [NWORDS-1:0][31:0] live;
    logic [NWORDS-1:0][31:0] valid;
    logic [NLINES-1:0]       irq_d;
    logic                    wake_d;

    always_comb begin
        irq_d  = '0;
        wake_d = 1'b0;
        for (int w = 0; w < NWORDS; w++) begin
            live[w]  = status[w] & eff_en[w];
            valid[w] = '0;
            for (int p = 0; p < NLINES; p++) begin
                valid[w] = valid[w] | route_q[p][w];
                irq_d[p] = irq_d[p] | (|(live[w] & route_q[p][w]));
            end
            wake_d = wake_d | (|(live[w] & valid[w]));
        end
        wake_d = wake_d & sleeping;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out  <= '0;
            wake_out <= 1'b0;
        end else begin
            irq_out  <= irq_d;
            wake_out <= wake_d;
        end
    end
endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator
    import l2_irq_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int NLINES = 2,
    parameter logic [NWORDS*32-1:0] FWD_INIT = {{(NWORDS*32-8){1'b0}}, 8'hFF},
    parameter bit WAKE_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NWORDS*32-1:0]   src_in,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic                   sleep_req,
    output logic [NLINES-1:0]      irq_out,
    output logic                   wake_out
);
    logic [NWORDS-1:0][31:0]              status_q;
    logic [NWORDS-1:0][31:0]              en_q;
    logic [NWORDS-1:0][31:0]              wake_q;
    logic [NWORDS-1:0][31:0]              eff_en;
    logic [NLINES-1:0][NWORDS-1:0][31:0]  route_q;
    logic [NWORDS*32-1:0]                 sync_flat;
    pwr_state_t                           state_q, state_d;
    logic                                 sleeping;

    l2_irq_sync #(.W(NWORDS*32)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(src_in), .q_out(sync_flat)
    );
    assign status_q = sync_flat;

    l2_irq_regs #(.NWORDS(NWORDS), .NLINES(NLINES), .FWD_INIT(FWD_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status(status_q), .en_q(en_q), .wake_q(wake_q), .route_q(route_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:   if (sleep_req)  state_d = PS_SLEEP;
            PS_SLEEP: if (!sleep_req) state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        sleeping = 1'b0;
        eff_en   = en_q;
        unique case (state_q)
            PS_RUN: ;
            PS_SLEEP: begin
                sleeping = WAKE_EN;
                for (int w = 0; w < NWORDS; w++)
                    if (WAKE_EN) eff_en[w] = en_q[w] | wake_q[w];
            end
        endcase
    end

    l2_irq_route #(.NWORDS(NWORDS), .NLINES(NLINES)) u_route (
        .clk(clk), .rst_n(rst_n), .sleeping(sleeping), .status(status_q),
        .eff_en(eff_en), .route_q(route_q), .irq_out(irq_out), .wake_out(wake_out)
    );
endmodule

// File: rtl/l2_irq_aggregator_chk.sv
module l2_irq_aggregator_chk
    import l2_irq_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int NLINES = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_sel,
    input logic                    bus_wr,
    input logic                    sleep_req,
    input logic [NLINES-1:0]       irq_out,
    input logic                    wake_out,
    input pwr_state_t              state_q,
    input logic [NWORDS-1:0][31:0] status_q,
    input logic [NWORDS-1:0][31:0] en_q
);
    // R9: wake only follows a cycle in the low-power state
    a_r9_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_out |-> $past(state_q == PS_SLEEP));

    // R3: no status bit set means no line next cycle
    a_r3_quiet_status: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |=> (irq_out == '0));

    // R8: entering the low-power state only on request
    a_r8_sleep_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == PS_SLEEP) |-> $past(sleep_req));

    // R8: leaving the low-power state only when the request drops
    a_r8_wake_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == PS_SLEEP) |-> !$past(sleep_req));

    // R2: enable registers change only through a bus write
    a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(en_q));
endmodule

bind l2_irq_aggregator l2_irq_aggregator_chk #(.NWORDS(NWORDS), .NLINES(NLINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .sleep_req(sleep_req), .irq_out(irq_out), .wake_out(wake_out),
    .state_q(state_q), .status_q(status_q), .en_q(en_q)
);

// File: tb/l2_irq_aggregator_test.sv
module l2_irq_aggregator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sleep_req = 1'b0;
    logic [1:0]  irq_out;
    logic        wake_out;
    int          n_checks = 0, n_fail = 0;

    always #10 clk = ~clk;

    l2_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sleep_req(sleep_req), .irq_out(irq_out),
        .wake_out(wake_out)
    );

    // {src word0, src word1, expected irq_out}
    localparam logic [65:0] VEC [8] = '{
        {32'h0000_0001, 32'h0000_0000, 2'b01},
        {32'h0000_0010, 32'h0000_0000, 2'b10},
        {32'h0000_0011, 32'h0000_0000, 2'b11},
        {32'h0000_0100, 32'h0000_0000, 2'b00},
        {32'h0000_0000, 32'h0000_0001, 2'b10},
        {32'h0000_0000, 32'h0001_0000, 2'b00},
        {32'h0000_0000, 32'h0000_0000, 2'b00},
        {32'h0000_0008, 32'h0000_8000, 2'b11}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        check("R3 reset irq", 32'(irq_out), 32'h0);
        check("R9 reset wake", 32'(wake_out), 32'h0);
        bus_read(8'h00, rd); check("R2 enable reset", rd, 32'h0000_00FF);
        bus_read(8'h54, rd); check("R4 route reset", rd, 32'hFFFF_FFFF);

        // configuration
        bus_write(8'h40, 32'h0000_000F);
        bus_write(8'h44, 32'h0000_0000);
        bus_write(8'h50, 32'h0000_00F0);
        bus_write(8'h08, 32'h0000_FFFF);
        bus_read(8'h40, rd); check("R4 route readback", rd, 32'h0000_000F);
        bus_read(8'h08, rd); check("R2 enable readback", rd, 32'h0000_FFFF);

        // R5 routing vectors
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            src_in = {VEC[i][33:2], VEC[i][65:34]};
            settle();
            check("R5 routed lines", 32'(irq_out), 32'(VEC[i][1:0]));
            bus_read(8'h04, rd); check("R1 status word0", rd, VEC[i][65:34]);
        end

        // R1: status shows disabled source, R2: status write ignored
        @(negedge clk) src_in = 64'h0000_0000_0000_8000;
        settle();
        bus_write(8'h04, 32'h0000_0000);
        bus_read(8'h04, rd); check("R1 raw status", rd, 32'h0000_8000);
        check("R2 status write no effect", 32'(irq_out), 32'h0);

        // R3 latency
        @(negedge clk) src_in = 64'h0000_0000_0000_0002;
        repeat (2) @(posedge clk);
        @(negedge clk); check("R3 not yet", 32'(irq_out), 32'h0);
        @(posedge clk);
        @(negedge clk); check("R3 third edge", 32'(irq_out), 32'h1);

        // R7 level hold, R6 mask/unmask
        settle(); check("R7 level held", 32'(irq_out), 32'h1);
        bus_write(8'h00, 32'h0000_00FD);
        @(posedge clk); @(negedge clk);
        check("R6 masked", 32'(irq_out), 32'h0);
        bus_write(8'h00, 32'h0000_00FF);
        @(posedge clk); @(negedge clk);
        check("R6 unmasked", 32'(irq_out), 32'h1);
        @(negedge clk) src_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); check("R7 still high", 32'(irq_out), 32'h1);
        @(posedge clk); @(negedge clk);
        check("R7 falls", 32'(irq_out), 32'h0);

        // R8/R9/R10 low-power behaviour
        bus_write(8'h40, 32'h0000_010F);
        bus_write(8'hD0, 32'h0000_0300);
        @(negedge clk) src_in = 64'h0000_0000_0000_0100;
        settle();
        check("R9 no wake in run", 32'(wake_out), 32'h0);
        check("R8 run uses enable", 32'(irq_out), 32'h0);
        @(negedge clk) sleep_req = 1'b1;
        settle();
        check("R9 wake in sleep", 32'(wake_out), 32'h1);
        check("R8 sleep enable widened", 32'(irq_out), 32'h1);
        @(negedge clk) src_in = 64'h0000_0000_0000_0200;
        settle();
        check("R10 unused no wake", 32'(wake_out), 32'h0);
        check("R10 unused no line", 32'(irq_out), 32'h0);
        @(negedge clk) begin src_in = 64'h0000_0000_0000_0100; sleep_req = 1'b0; end
        settle();
        check("R9 wake off after resume", 32'(wake_out), 32'h0);
        check("R8 enable restored", 32'(irq_out), 32'h0);
        bus_read(8'h00, rd); check("R8 enable unchanged", rd, 32'h0000_00FF);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule